// File: doc/BRIEF.md
# ASID-Tagged TLB Address Translator

This block turns a 32-bit logical address into a 29-bit physical address. It uses a small fully associative translation buffer. Each entry is tagged with an 8-bit address space identifier (ASID). A lookup request carries the logical address, the MMU enable and the virtual-memory mode select. One cycle later the block answers with one of four outcomes:

- a translated physical address together with the entry's page control bits;
- a miss;
- a protection violation;
- when translation is switched off, the logical address with its top three bits cleared.

Software fills the buffer through a write port, one entry per cycle, usually from a miss handler that walks the page table in memory. Software also sets the ASID of the running process through a register port. A global invalidate empties the whole buffer in one cycle.

In multiple virtual memory mode, an entry must match both the virtual page number and the current ASID. Processes can therefore share the logical space without a flush on a context switch. In single virtual memory mode, only the page number selects an entry, and the ASID acts as a protection check.

Top module: `asid_tlb_xlate`

## Requirements
- R1: After reset all entries are invalid, the current ASID reads 0, and every response output (`rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_prot`, `rsp_multi`, `rsp_paddr`, `rsp_ctl`) is 0.
- R2: A request with `req_valid`=1 produces `rsp_valid`=1 exactly one cycle later. In a cycle with no request, the next cycle shows `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_prot` and `rsp_multi` all at 0.
- R3: With `req_mmu_en`=0, `rsp_paddr` equals the low 29 bits of the logical address, with `rsp_hit`, `rsp_miss`, `rsp_prot`, `rsp_multi` and `rsp_ctl` all 0. As a result, 0x00001000, 0x80001000, 0xA0001000 and 0xC0001000 all give 0x00001000.
- R4: With `req_mmu_en`=1 and `req_multi_vm`=1 (multiple mode), an entry hits when it is valid, its 20-bit page number equals logical address bits 31:12, and its ASID equals the current ASID. A hit gives `rsp_hit`=1, `rsp_paddr` = {entry PPN (17 bits), logical bits 11:0}, and `rsp_ctl` = the entry's 4 control bits.
- R5: In multiple mode, an entry whose ASID differs from the current ASID does not hit. Writing a new current ASID through `asid_we`/`asid_wdata` selects a different entry for the same page number, with no flush.
- R6: With `req_multi_vm`=0 (single mode), entries are matched on the page number alone. If the selected entry's ASID differs from the current ASID, the block reports `rsp_prot`=1, `rsp_hit`=0 and `rsp_paddr`=0. If the ASID agrees, it reports a hit as in R4.
- R7: When no entry matches with translation on, the block reports `rsp_miss`=1, with `rsp_paddr`=0 and `rsp_ctl`=0. At most one of `rsp_hit`, `rsp_miss` and `rsp_prot` is ever 1.
- R8: `wr_en`=1 writes page number, ASID, PPN and control bits into entry `wr_idx` and marks the entry valid. A later write to the same index replaces the old contents.
- R9: `inv_all`=1 clears every valid bit in one cycle. When it coincides with `wr_en`, the invalidate wins and the written entry is not valid afterwards.
- R10: If more than one entry matches under the active mode's rule, `rsp_multi`=1 and the result comes from the lowest-index matching entry.
- R11: A lookup uses the buffer contents and current ASID as they stood before the same clock edge. A write, an invalidate or an ASID write in the request's own cycle affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asid_we | input | 1 | Load the current ASID register |
| asid_wdata | input | 8 | New current ASID |
| cur_asid | output | 8 | Current ASID register value |
| wr_en | input | 1 | Write one buffer entry |
| wr_idx | input | 3 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number for the entry |
| wr_asid | input | 8 | ASID tag for the entry |
| wr_ppn | input | 17 | Physical page number for the entry |
| wr_ctl | input | 4 | Page control bits for the entry |
| inv_all | input | 1 | Clear all valid bits |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Logical address to translate |
| req_mmu_en | input | 1 | 1: translate, 0: pass through |
| req_multi_vm | input | 1 | 1: multiple virtual memory mode, 0: single |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_paddr | output | 29 | Physical address |
| rsp_ctl | output | 4 | Page control bits of the hit entry |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No matching entry |
| rsp_prot | output | 1 | Single-mode ASID protection violation |
| rsp_multi | output | 1 | More than one entry matched |

## Verification
Lookup and table maintenance can land in the same cycle. A request may coincide with an entry write, a global invalidate or an ASID load. The bench provokes each case by driving the request and the maintenance strobe on the same negative edge. It judges the outcome as follows:

- A coinciding write must still give a miss, and a coinciding invalidate must still give a hit.
- A coinciding ASID load must still give the result for the old ASID.
- A repeat lookup one cycle later must show the new state.

A separate case drives invalidate and write together. A following lookup then confirms that the invalidate took precedence.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 29;
  localparam int OFF_W    = 12;
  localparam int VPN_W    = VA_W - OFF_W;
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int ASID_W   = 8;
  localparam int CTL_W    = 4;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [CTL_W-1:0] ctl;
  } tlb_payload_t;
endpackage

// File: rtl/tlb_tag_cam.sv
module tlb_tag_cam
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic               inv_all,
  input  logic [VPN_W-1:0]   look_vpn,
  input  logic [ASID_W-1:0]  look_asid,
  input  logic               use_asid,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] asid_ok
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (inv_all) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      asid_q[wr_idx] <= wr_asid;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic vpn_eq;
    assign vpn_eq       = valid_q[e] && (vpn_q[e] == look_vpn);
    assign asid_ok[e]   = (asid_q[e] == look_asid);
    assign match_vec[e] = vpn_eq && (!use_asid || asid_ok[e]);
  end

  // R9
  inv_clears_chk: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (valid_q == '0));
  // R8
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !inv_all) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/tlb_payload_ram.sv
module tlb_payload_ram
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic         clk,
  input  logic         we,
  input  logic [IDX_W-1:0] waddr,
  input  tlb_payload_t wdata,
  input  logic [IDX_W-1:0] raddr,
  output tlb_payload_t rdata
);
  tlb_payload_t mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] req_vec,
  output logic               any,
  output logic               several,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any     = 1'b0;
    several = 1'b0;
    idx     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (req_vec[i]) begin
        if (any) several = 1'b1;
        else idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/asid_tlb_xlate.sv
module asid_tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              asid_we,
  input  logic [ASID_W-1:0] asid_wdata,
  output logic [ASID_W-1:0] cur_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [CTL_W-1:0]  wr_ctl,
  input  logic              inv_all,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_mmu_en,
  input  logic              req_multi_vm,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [CTL_W-1:0]  rsp_ctl,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_prot,
  output logic              rsp_multi
);
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] asid_ok;
  logic               sel_any;
  logic               sel_several;
  logic [IDX_W-1:0]   sel_idx;
  tlb_payload_t       sel_pay;
  tlb_payload_t       wr_pay;

  always_ff @(posedge clk) begin
    if (rst)          cur_asid <= '0;
    else if (asid_we) cur_asid <= asid_wdata;
  end

  assign wr_pay.ppn = wr_ppn;
  assign wr_pay.ctl = wr_ctl;

  tlb_tag_cam #(.ENTRIES(ENTRIES)) cam_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_vpn    (wr_vpn),
    .wr_asid   (wr_asid),
    .inv_all   (inv_all),
    .look_vpn  (req_vaddr[VA_W-1:OFF_W]),
    .look_asid (cur_asid),
    .use_asid  (req_multi_vm),
    .match_vec (match_vec),
    .asid_ok   (asid_ok)
  );

  tlb_prio_enc #(.ENTRIES(ENTRIES)) enc_i (
    .req_vec (match_vec),
    .any     (sel_any),
    .several (sel_several),
    .idx     (sel_idx)
  );

  tlb_payload_ram #(.ENTRIES(ENTRIES)) ram_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (wr_pay),
    .raddr (sel_idx),
    .rdata (sel_pay)
  );

  logic [PA_W-1:0]  nx_paddr;
  logic [CTL_W-1:0] nx_ctl;
  logic             nx_hit, nx_miss, nx_prot, nx_multi;

  always_comb begin
    nx_paddr = '0;
    nx_ctl   = '0;
    nx_hit   = 1'b0;
    nx_miss  = 1'b0;
    nx_prot  = 1'b0;
    nx_multi = 1'b0;
    if (req_valid) begin
      if (!req_mmu_en) begin
        nx_paddr = req_vaddr[PA_W-1:0];
      end else if (!sel_any) begin
        nx_miss = 1'b1;
      end else begin
        nx_multi = sel_several;
        if (!req_multi_vm && !asid_ok[sel_idx]) begin
          nx_prot = 1'b1;
        end else begin
          nx_hit   = 1'b1;
          nx_paddr = {sel_pay.ppn, req_vaddr[OFF_W-1:0]};
          nx_ctl   = sel_pay.ctl;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_ctl   <= '0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_multi <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_paddr <= nx_paddr;
      rsp_ctl   <= nx_ctl;
      rsp_hit   <= nx_hit;
      rsp_miss  <= nx_miss;
      rsp_prot  <= nx_prot;
      rsp_multi <= nx_multi;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(rsp_valid || rsp_hit || rsp_miss || rsp_prot || rsp_multi));
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_miss, rsp_prot}));
  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_mmu_en) |=>
      (rsp_paddr == $past(req_vaddr[PA_W-1:0])) && !rsp_hit && !rsp_miss);
  // R10
  lowest_grant_chk: assert property (@(posedge clk) disable iff (rst)
    sel_any |-> (match_vec[sel_idx] &&
      ((match_vec & ((ENTRIES'(1) << sel_idx) - ENTRIES'(1))) == '0)));
  // R5
  asid_load_chk: assert property (@(posedge clk) disable iff (rst)
    asid_we |=> (cur_asid == $past(asid_wdata)));
endmodule

// File: tb/asid_tlb_xlate_tb_top.sv
module asid_tlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        asid_we;
  logic [7:0]  asid_wdata;
  logic [7:0]  cur_asid;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [19:0] wr_vpn;
  logic [7:0]  wr_asid;
  logic [16:0] wr_ppn;
  logic [3:0]  wr_ctl;
  logic        inv_all;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_mmu_en;
  logic        req_multi_vm;
  logic        rsp_valid;
  logic [28:0] rsp_paddr;
  logic [3:0]  rsp_ctl;
  logic        rsp_hit, rsp_miss, rsp_prot, rsp_multi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  asid_tlb_xlate dut_i (
    .clk(clk), .rst(rst),
    .asid_we(asid_we), .asid_wdata(asid_wdata), .cur_asid(cur_asid),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
    .wr_ppn(wr_ppn), .wr_ctl(wr_ctl), .inv_all(inv_all),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_mmu_en(req_mmu_en),
    .req_multi_vm(req_multi_vm),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_ctl(rsp_ctl),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_prot(rsp_prot),
    .rsp_multi(rsp_multi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    asid_we = 0; asid_wdata = 0; wr_en = 0; wr_idx = 0; wr_vpn = 0;
    wr_asid = 0; wr_ppn = 0; wr_ctl = 0; inv_all = 0;
    req_valid = 0; req_vaddr = 0; req_mmu_en = 0; req_multi_vm = 0;
  endtask

  // Response packed as {valid, hit, miss, prot, multi, ctl}
  function automatic logic [31:0] flags();
    return {23'd0, rsp_valid, rsp_hit, rsp_miss, rsp_prot, rsp_multi, rsp_ctl};
  endfunction

  function automatic logic [31:0] mkflags(bit h, bit m, bit p, bit mu, logic [3:0] c);
    return {23'd0, 1'b1, h, m, p, mu, c};
  endfunction

  task automatic write_entry(input int idx, input logic [19:0] vpn, input logic [7:0] asid,
                             input logic [16:0] ppn, input logic [3:0] ctl);
    wr_en = 1; wr_idx = 3'(idx); wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn; wr_ctl = ctl;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_asid(input logic [7:0] a);
    asid_we = 1; asid_wdata = a;
    @(negedge clk);
    asid_we = 0;
  endtask

  // Drives a request for one cycle; response is sampled at the following negedge.
  task automatic lookup(input logic [31:0] va, input bit en, input bit multi);
    req_valid = 1; req_vaddr = va; req_mmu_en = en; req_multi_vm = multi;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    check("R1 flags", flags(), 32'd0);
    check("R1 paddr", 32'(rsp_paddr), 32'd0);
    check("R1 asid", 32'(cur_asid), 32'd0);
    lookup(32'h0000_5000, 1, 1);
    check("R1 empty miss", flags(), mkflags(0, 1, 0, 0, 4'h0));
  endtask

  task automatic t_passthrough();
    logic [31:0] va [4] = '{32'h0000_1000, 32'h8000_1000, 32'hA000_1000, 32'hC000_1000};
    foreach (va[i]) begin
      lookup(va[i], 0, 1);
      check("R3 alias paddr", 32'(rsp_paddr), 32'h0000_1000);
      check("R3 flags", flags(), mkflags(0, 0, 0, 0, 4'h0));
    end
    lookup(32'hFFFF_FFFF, 0, 0);
    check("R3 top bits cleared", 32'(rsp_paddr), 32'h1FFF_FFFF);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R2 idle", flags(), 32'd0);
    req_valid = 1; req_vaddr = 32'h0; req_mmu_en = 0;
    @(negedge clk);
    idle_inputs();
    check("R2 valid after one cycle", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    check("R2 drop after request", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_hit_multi();
    write_entry(2, 20'h12345, 8'd5, 17'h1ABCD, 4'hA);
    set_asid(8'd5);
    check("R5 asid reg", 32'(cur_asid), 32'd5);
    lookup(32'h1234_5678, 1, 1);
    check("R4 hit flags", flags(), mkflags(1, 0, 0, 0, 4'hA));
    check("R4 paddr", 32'(rsp_paddr), 32'h1ABC_D678);
  endtask

  task automatic t_asid_switch();
    write_entry(3, 20'h12345, 8'd6, 17'h00111, 4'h5);
    set_asid(8'd6);
    lookup(32'h1234_5678, 1, 1);
    check("R5 asid6 paddr", 32'(rsp_paddr), 32'h0011_1678);
    check("R5 asid6 flags", flags(), mkflags(1, 0, 0, 0, 4'h5));
    set_asid(8'd5);
    lookup(32'h1234_5678, 1, 1);
    check("R5 asid5 paddr", 32'(rsp_paddr), 32'h1ABC_D678);
    set_asid(8'd7);
    lookup(32'h1234_5678, 1, 1);
    check("R7 asid mismatch miss", flags(), mkflags(0, 1, 0, 0, 4'h0));
    check("R7 miss paddr", 32'(rsp_paddr), 32'd0);
  endtask

  task automatic t_single();
    set_asid(8'd5);
    lookup(32'h1234_5678, 1, 0);
    check("R6 single hit flags", flags(), mkflags(1, 0, 0, 1, 4'hA));
    check("R6 single paddr", 32'(rsp_paddr), 32'h1ABC_D678);
    set_asid(8'd6);
    lookup(32'h1234_5678, 1, 0);
    check("R6 prot flags", flags(), mkflags(0, 0, 1, 1, 4'h0));
    check("R6 prot paddr", 32'(rsp_paddr), 32'd0);
  endtask

  task automatic t_multi_hit();
    set_asid(8'd9);
    write_entry(5, 20'h00ABC, 8'd9, 17'h15555, 4'hC);
    write_entry(0, 20'h00ABC, 8'd9, 17'h0AAAA, 4'h3);
    lookup(32'h00AB_C123, 1, 1);
    check("R10 multi flags", flags(), mkflags(1, 0, 0, 1, 4'h3));
    check("R10 lowest paddr", 32'(rsp_paddr), 32'h0AAA_A123);
    write_entry(0, 20'h00ABD, 8'd9, 17'h0AAAA, 4'h3);
    lookup(32'h00AB_C123, 1, 1);
    check("R8 overwrite flags", flags(), mkflags(1, 0, 0, 0, 4'hC));
    check("R8 overwrite paddr", 32'(rsp_paddr), 32'h1555_5123);
  endtask

  task automatic t_same_cycle();
    // Lookup and write together: old contents seen
    wr_en = 1; wr_idx = 3'd1; wr_vpn = 20'h0F0F0; wr_asid = 8'd9; wr_ppn = 17'h01234; wr_ctl = 4'h7;
    req_valid = 1; req_vaddr = 32'h0F0F_0000; req_mmu_en = 1; req_multi_vm = 1;
    @(negedge clk);
    idle_inputs();
    check("R11 write same cycle miss", flags(), mkflags(0, 1, 0, 0, 4'h0));
    lookup(32'h0F0F_0000, 1, 1);
    check("R11 write then hit", 32'(rsp_paddr), 32'h0123_4000);
    // Lookup and invalidate together: still hits
    inv_all = 1;
    req_valid = 1; req_vaddr = 32'h0F0F_0000; req_mmu_en = 1; req_multi_vm = 1;
    @(negedge clk);
    idle_inputs();
    check("R11 inv same cycle hit", flags(), mkflags(1, 0, 0, 0, 4'h7));
    lookup(32'h0F0F_0000, 1, 1);
    check("R9 after invalidate miss", flags(), mkflags(0, 1, 0, 0, 4'h0));
    lookup(32'h00AB_C123, 1, 1);
    check("R9 all entries gone", flags(), mkflags(0, 1, 0, 0, 4'h0));
    // Lookup and ASID load together: old ASID used
    write_entry(4, 20'h33333, 8'd9, 17'h00042, 4'h1);
    asid_we = 1; asid_wdata = 8'h10;
    req_valid = 1; req_vaddr = 32'h3333_3ABC; req_mmu_en = 1; req_multi_vm = 1;
    @(negedge clk);
    idle_inputs();
    check("R11 asid same cycle hit", 32'(rsp_paddr), 32'h0004_2ABC);
    lookup(32'h3333_3ABC, 1, 1);
    check("R11 new asid miss", flags(), mkflags(0, 1, 0, 0, 4'h0));
  endtask

  task automatic t_inv_vs_write();
    set_asid(8'd9);
    inv_all = 1; wr_en = 1; wr_idx = 3'd6; wr_vpn = 20'h44444; wr_asid = 8'd9;
    wr_ppn = 17'h00077; wr_ctl = 4'h2;
    @(negedge clk);
    idle_inputs();
    lookup(32'h4444_4000, 1, 1);
    check("R9 invalidate beats write", flags(), mkflags(0, 1, 0, 0, 4'h0));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_idle();
    t_passthrough();
    t_hit_multi();
    t_asid_switch();
    t_single();
    t_multi_hit();
    t_same_cycle();
    t_inv_vs_write();
    done = 1;
    finish_run();
  end
endmodule